// File: doc/BRIEF.md
# Critical-Word-First Instruction Line Refill

This block services an instruction-cache miss. Fetch hands it the address of the missed instruction. The block then requests the shared memory bus and waits through arbitration for as many cycles as it takes. When the grant arrives, it places the address of the critical double word on the address bus. It then accepts a four-beat burst that starts at the double word holding the missed instruction and wraps around the 32-byte line. Every accepted beat goes out on a line-buffer write port, tagged with its double-word slot within the line. The two 32-bit instructions in each beat also pass through a small pair queue to the instruction queue, in the order the beats arrived.

Forwarding starts with the first beat. It does not wait for the whole line to be filled. The first pair reaches the instruction queue two cycles after it appears on the bus, and each later pair follows one cycle after the one before it. A ready/valid handshake towards the instruction queue can hold forwarding back without slowing the bus: beats keep landing in the line buffer and wait in the pair queue. Fetch is stalled for the whole time a fill is in progress. A flush abandons the fill. Any beats of that burst still to come are counted off the bus and discarded.

The controller has five states:
- FS_IDLE: no fill in progress. A miss without a flush moves to FS_ARB.
- FS_ARB: the bus request is raised. A flush returns to FS_IDLE. A grant drives the address and moves to FS_DATA.
- FS_DATA: beats are accepted. The last beat moves to FS_FWD, or to FS_IDLE if a flush comes with it. A flush on any earlier beat moves to FS_DRAIN.
- FS_FWD: the queued pairs drain. Once the last pair is handed over, or on a flush, the state returns to FS_IDLE.
- FS_DRAIN: the rest of the aborted burst is discarded. The last beat returns the state to FS_IDLE.

Top module: `ifill_refill`

## Requirements
- R1: In the cycle after a miss_valid is seen in the idle state without flush, bus_req and fetch_stall are high. bus_req stays high on every cycle without bus_grant until the grant arrives.
- R2: addr_valid is high in exactly the one cycle in which bus_req and bus_grant are both high, and only if there is no flush. In that cycle addr_out equals the miss address with its low three bits cleared. bus_req is low from the next cycle.
- R3: A fill accepts exactly four beats, starting in the cycle after the address. A beat_valid seen outside the data phase produces no line-buffer write and no queue entry.
- R4: With crit = miss_addr[4:3], the n-th accepted beat (n = 0..3) is written with lb_idx = (crit + n) mod 4, and lb_data equals beat_data in the same cycle.
- R5: For each beat, beat_data[31:0] is presented as q_insn0 and beat_data[63:32] as q_insn1. Both instructions travel together as one queue entry.
- R6: If the queue is ready, the pair of a beat seen on the bus in cycle t is presented with q_valid in cycle t+2. Each later pair follows one cycle after the previous one.
- R7: While q_valid is high and q_ready is low, q_valid stays high and the presented pair does not change. Beats keep being written to the line buffer. Once the queue accepts again, all four pairs are delivered in arrival order.
- R8: A flush during arbitration suppresses the address in that cycle. bus_req and fetch_stall are low in the next cycle.
- R9: A flush during the data phase suppresses the line-buffer write of the beat in that cycle and of every later beat of that burst. From the next cycle q_valid is low and no pair of that fill is forwarded. fetch_stall stays high until the burst's last beat has passed and drops in the cycle after it.
- R10: fetch_stall drops in the cycle after the last pair is handed over. A flush in the idle state has no effect, and a miss together with that flush is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_valid | input | 1 | Fetch reports an instruction-cache miss |
| miss_addr | input | 32 | Byte address of the missed instruction |
| flush | input | 1 | Abandon the current fill |
| fetch_stall | output | 1 | Fetch must hold while a fill is active |
| bus_req | output | 1 | Request for the address and data buses |
| bus_grant | input | 1 | Bus granted to this block |
| addr_valid | output | 1 | Address phase of the burst |
| addr_out | output | 32 | Address of the critical double word |
| beat_valid | input | 1 | Data beat present on the bus |
| beat_data | input | 64 | One double word of the line |
| lb_we | output | 1 | Line-buffer write strobe |
| lb_idx | output | 2 | Double-word slot within the line |
| lb_data | output | 64 | Double word written to the line buffer |
| q_valid | output | 1 | An instruction pair is offered to the queue |
| q_ready | input | 1 | Instruction queue accepts the pair |
| q_insn0 | output | 32 | First instruction of the pair |
| q_insn1 | output | 32 | Second instruction of the pair |

## Verification
Some properties are checked by assertions on every cycle:
- the bus request is held until granted, and a miss leads to a request;
- the address phase lasts a single cycle;
- the line-buffer slot steps by one, wrapping, from one beat to the next;
- the pair queue never overflows, and a stalled pair is held unchanged;
- a flush empties the queue output;
- a pair written into an empty queue surfaces two bus cycles after its beat.

Other behaviour can only be shown by the directed scenarios:
- the exact wrapped slot order for different critical words;
- the mapping of instruction halves;
- complete in-order delivery after a long back-pressure stall;
- discarding the tail of an aborted burst;
- the cycle in which fetch_stall drops.

// File: rtl/ifill_pkg.sv
package ifill_pkg;

    typedef enum logic [2:0] {
        FS_IDLE,
        FS_ARB,
        FS_DATA,
        FS_FWD,
        FS_DRAIN
    } fill_state_e;

endpackage

// File: rtl/ifill_ctrl.sv
module ifill_ctrl
    import ifill_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic miss_valid,
    input  logic flush,
    input  logic bus_grant,
    input  logic beat_valid,
    input  logic last_beat,
    input  logic q_drained,
    output logic bus_req,
    output logic addr_valid,
    output logic beat_take,
    output logic beat_count,
    output logic fill_start,
    output logic fetch_stall,
    output logic pairs_clear
);

    fill_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FS_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FS_IDLE: begin
                if (miss_valid && !flush) state_d = FS_ARB;
            end
            FS_ARB: begin
                if (flush)          state_d = FS_IDLE;
                else if (bus_grant) state_d = FS_DATA;
            end
            FS_DATA: begin
                if (beat_valid && last_beat) state_d = flush ? FS_IDLE : FS_FWD;
                else if (flush)              state_d = FS_DRAIN;
            end
            FS_FWD: begin
                if (flush || q_drained) state_d = FS_IDLE;
            end
            FS_DRAIN: begin
                if (beat_valid && last_beat) state_d = FS_IDLE;
            end
            default: state_d = FS_IDLE;
        endcase
    end

    // Output logic
    always_comb begin
        bus_req     = 1'b0;
        addr_valid  = 1'b0;
        beat_take   = 1'b0;
        beat_count  = 1'b0;
        fill_start  = 1'b0;
        fetch_stall = 1'b1;
        pairs_clear = flush;
        unique case (state_q)
            FS_IDLE: begin
                fetch_stall = 1'b0;
                fill_start  = miss_valid && !flush;
            end
            FS_ARB: begin
                bus_req    = 1'b1;
                addr_valid = bus_grant && !flush;
            end
            FS_DATA: begin
                beat_take  = beat_valid && !flush;
                beat_count = beat_valid;
            end
            FS_FWD: begin
            end
            FS_DRAIN: begin
                beat_count = beat_valid;
            end
            default: begin
            end
        endcase
    end

    // R1: a request that is still waiting for its grant is held
    assert_req_held_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_grant && !flush) |=> bus_req);

    // R1: an accepted miss leads to a request in the next cycle
    assert_miss_to_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
        fill_start |=> bus_req);

    // R2: the address phase lasts a single cycle and ends the request
    assert_addr_once_R2: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid |=> (!addr_valid && !bus_req));

endmodule

// File: rtl/ifill_beat_seq.sv
module ifill_beat_seq #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BEATS = 4,
    parameter int DW_OFF_W   = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          fill_start,
    input  logic [ADDR_W-1:0]             miss_addr,
    input  logic                          addr_issue,
    input  logic                          beat_count,
    input  logic                          beat_take,
    output logic [ADDR_W-1:0]             addr_out,
    output logic [$clog2(LINE_BEATS)-1:0] lb_idx,
    output logic                          last_beat
);

    localparam int IDX_W = $clog2(LINE_BEATS);
    localparam int HI_W  = ADDR_W - DW_OFF_W;

    logic [HI_W-1:0]  dw_addr_q;
    logic [IDX_W-1:0] cnt_q;
    logic [IDX_W-1:0] crit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dw_addr_q <= '0;
        end else if (fill_start) begin
            dw_addr_q <= miss_addr[ADDR_W-1:DW_OFF_W];
        end
    end

    // Beat counter: restarted on the address phase, counts every beat of the burst
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (addr_issue) begin
            cnt_q <= '0;
        end else if (beat_count) begin
            cnt_q <= cnt_q + IDX_W'(1);
        end
    end

    assign crit      = dw_addr_q[IDX_W-1:0];
    assign addr_out  = {dw_addr_q, {DW_OFF_W{1'b0}}};
    assign lb_idx    = crit + cnt_q;
    assign last_beat = (cnt_q == IDX_W'(LINE_BEATS - 1));

    // R4: consecutive writes go to consecutive slots, modulo the line
    assert_lb_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_take ##1 beat_take) |-> (lb_idx == $past(lb_idx) + IDX_W'(1)));

endmodule

// File: rtl/ifill_pair_fifo.sv
module ifill_pair_fifo #(
    parameter int PAIR_W = 64,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr,
    input  logic [PAIR_W-1:0] din,
    input  logic              q_ready,
    output logic              q_valid,
    output logic [PAIR_W-1:0] q_pair,
    output logic              drained
);

    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [PAIR_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              load;

    assign load    = (cnt_q != '0) && (!q_valid || q_ready);
    assign drained = (cnt_q == '0) && (!q_valid || q_ready);

    // Storage array, written without reset
    always_ff @(posedge clk) begin
        if (wr && !clr) mem[wr_ptr_q] <= din;
    end

    // Pointers, fill count and the output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            cnt_q    <= '0;
            q_valid  <= 1'b0;
            q_pair   <= '0;
        end else if (clr) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            cnt_q    <= '0;
            q_valid  <= 1'b0;
        end else begin
            if (wr) wr_ptr_q <= wr_ptr_q + PTR_W'(1);
            if (load) begin
                rd_ptr_q <= rd_ptr_q + PTR_W'(1);
                q_pair   <= mem[rd_ptr_q];
                q_valid  <= 1'b1;
            end else if (q_ready) begin
                q_valid  <= 1'b0;
            end
            cnt_q <= cnt_q + CNT_W'(wr) - CNT_W'(load);
        end
    end

    // R7: never write into a full queue
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !clr) |-> (cnt_q < CNT_W'(DEPTH)) || load);

    // R7: an offered pair is held until accepted
    assert_hold_stalled_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (q_valid && !q_ready && !clr) |=> (q_valid && $stable(q_pair)));

    // R9: a flush empties the output
    assert_flush_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !q_valid);

    // R6: a pair written into an empty queue is offered two cycles after its beat
    assert_two_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !clr && cnt_q == '0 && !q_valid ##1 !clr) |=> q_valid);

endmodule

// File: rtl/ifill_refill.sv
module ifill_refill #(
    parameter int ADDR_W     = 32,
    parameter int INSN_W     = 32,
    parameter int LINE_BEATS = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          miss_valid,
    input  logic [ADDR_W-1:0]             miss_addr,
    input  logic                          flush,
    output logic                          fetch_stall,
    output logic                          bus_req,
    input  logic                          bus_grant,
    output logic                          addr_valid,
    output logic [ADDR_W-1:0]             addr_out,
    input  logic                          beat_valid,
    input  logic [2*INSN_W-1:0]           beat_data,
    output logic                          lb_we,
    output logic [$clog2(LINE_BEATS)-1:0] lb_idx,
    output logic [2*INSN_W-1:0]           lb_data,
    output logic                          q_valid,
    input  logic                          q_ready,
    output logic [INSN_W-1:0]             q_insn0,
    output logic [INSN_W-1:0]             q_insn1
);

    localparam int BEAT_W   = 2 * INSN_W;
    localparam int DW_OFF_W = $clog2(BEAT_W / 8);

    logic beat_take, beat_count, fill_start, last_beat, q_drained, pairs_clear;
    logic [BEAT_W-1:0] q_pair;

    ifill_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .miss_valid  (miss_valid),
        .flush       (flush),
        .bus_grant   (bus_grant),
        .beat_valid  (beat_valid),
        .last_beat   (last_beat),
        .q_drained   (q_drained),
        .bus_req     (bus_req),
        .addr_valid  (addr_valid),
        .beat_take   (beat_take),
        .beat_count  (beat_count),
        .fill_start  (fill_start),
        .fetch_stall (fetch_stall),
        .pairs_clear (pairs_clear)
    );

    ifill_beat_seq #(
        .ADDR_W     (ADDR_W),
        .LINE_BEATS (LINE_BEATS),
        .DW_OFF_W   (DW_OFF_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .fill_start (fill_start),
        .miss_addr  (miss_addr),
        .addr_issue (addr_valid),
        .beat_count (beat_count),
        .beat_take  (beat_take),
        .addr_out   (addr_out),
        .lb_idx     (lb_idx),
        .last_beat  (last_beat)
    );

    ifill_pair_fifo #(
        .PAIR_W (BEAT_W),
        .DEPTH  (LINE_BEATS)
    ) u_pairs (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (pairs_clear),
        .wr      (beat_take),
        .din     (beat_data),
        .q_ready (q_ready),
        .q_valid (q_valid),
        .q_pair  (q_pair),
        .drained (q_drained)
    );

    assign lb_we   = beat_take;
    assign lb_data = beat_data;
    assign q_insn0 = q_pair[INSN_W-1:0];
    assign q_insn1 = q_pair[BEAT_W-1:INSN_W];

endmodule

// File: tb/ifill_refill_bench.sv
module ifill_refill_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        miss_valid = 1'b0;
    logic [31:0] miss_addr = '0;
    logic        flush = 1'b0;
    logic        fetch_stall;
    logic        bus_req;
    logic        bus_grant = 1'b0;
    logic        addr_valid;
    logic [31:0] addr_out;
    logic        beat_valid = 1'b0;
    logic [63:0] beat_data = '0;
    logic        lb_we;
    logic [1:0]  lb_idx;
    logic [63:0] lb_data;
    logic        q_valid;
    logic        q_ready = 1'b1;
    logic [31:0] q_insn0;
    logic [31:0] q_insn1;

    int errors = 0;
    int checks = 0;

    logic [63:0] qlog [8];
    logic [1:0]  lblog [8];
    int qn = 0;
    int lbn = 0;

    always #5 clk = ~clk;

    ifill_refill u_ifill_refill (
        .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_addr(miss_addr),
        .flush(flush), .fetch_stall(fetch_stall), .bus_req(bus_req),
        .bus_grant(bus_grant), .addr_valid(addr_valid), .addr_out(addr_out),
        .beat_valid(beat_valid), .beat_data(beat_data), .lb_we(lb_we),
        .lb_idx(lb_idx), .lb_data(lb_data), .q_valid(q_valid), .q_ready(q_ready),
        .q_insn0(q_insn0), .q_insn1(q_insn1)
    );

    // Record handshakes and line-buffer writes away from the active edge
    always @(negedge clk) begin
        if (q_valid && q_ready && qn < 8) begin
            qlog[qn] = {q_insn1, q_insn0};
            qn++;
        end
        if (lb_we && lbn < 8) begin
            lblog[lbn] = lb_idx;
            lbn++;
        end
    end

    function automatic logic [63:0] dw(input logic [7:0] seed, input int n);
        return {seed, 8'hA1, 16'(n), seed, 8'h5C, 16'(n + 16)};
    endfunction

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_logs();
        qn = 0;
        lbn = 0;
    endtask

    task automatic t_reset();
        #1;
        chk("R1 reset bus_req", 64'(bus_req), 0);
        chk("R10 reset fetch_stall", 64'(fetch_stall), 0);
        chk("R6 reset q_valid", 64'(q_valid), 0);
        chk("R3 reset lb_we", 64'(lb_we), 0);
    endtask

    // R1 R2 R3 R4 R5 R6 R10: arbitration over several cycles, wrapped burst, full-rate queue
    task automatic t_basic();
        clear_logs();
        miss_valid = 1'b1; miss_addr = 32'h1000_0014; #1;
        chk("R10 idle before miss", 64'(fetch_stall), 0);
        tick(); miss_valid = 1'b0; #1;
        chk("R1 req after miss", 64'(bus_req), 1);
        chk("R1 stall after miss", 64'(fetch_stall), 1);
        chk("R2 no addr before grant", 64'(addr_valid), 0);
        tick(); #1;
        chk("R1 req held", 64'(bus_req), 1);
        tick(); bus_grant = 1'b1; #1;
        chk("R2 addr with grant", 64'(addr_valid), 1);
        chk("R2 addr value", 64'(addr_out), 64'h1000_0010);
        tick(); bus_grant = 1'b0; beat_valid = 1'b1; beat_data = dw(8'h11, 0); #1;
        chk("R2 req drops", 64'(bus_req), 0);
        chk("R4 beat0 slot", 64'(lb_idx), 2);
        chk("R4 beat0 data", lb_data, dw(8'h11, 0));
        tick(); beat_data = dw(8'h11, 1); #1;
        chk("R4 beat1 slot", 64'(lb_idx), 3);
        chk("R6 not yet", 64'(q_valid), 0);
        tick(); beat_data = dw(8'h11, 2); #1;
        chk("R4 beat2 slot wraps", 64'(lb_idx), 0);
        chk("R6 pair0 at t+2", 64'(q_valid), 1);
        chk("R5 insn0 low half", 64'(q_insn0), 64'(dw(8'h11, 0)) & 64'hFFFF_FFFF);
        chk("R5 insn1 high half", 64'(q_insn1), dw(8'h11, 0) >> 32);
        tick(); beat_data = dw(8'h11, 3); #1;
        chk("R4 beat3 slot", 64'(lb_idx), 1);
        chk("R6 pair1 next cycle", {q_insn1, q_insn0}, dw(8'h11, 1));
        tick(); beat_data = dw(8'h11, 9); #1;
        chk("R3 fifth beat ignored", 64'(lb_we), 0);
        chk("R6 pair2", {q_insn1, q_insn0}, dw(8'h11, 2));
        tick(); beat_valid = 1'b0; #1;
        chk("R6 pair3", {q_insn1, q_insn0}, dw(8'h11, 3));
        chk("R10 stall while pairs pending", 64'(fetch_stall), 1);
        tick(); #1;
        chk("R3 no extra pair", 64'(q_valid), 0);
        chk("R10 stall released", 64'(fetch_stall), 0);
        chk("R3 four writes", 64'(lbn), 4);
        chk("R3 four pairs", 64'(qn), 4);
    endtask

    // R7: back-pressure across the whole burst
    task automatic t_stall();
        clear_logs();
        q_ready = 1'b0;
        miss_valid = 1'b1; miss_addr = 32'h2000_0008;
        tick(); miss_valid = 1'b0; bus_grant = 1'b1; #1;
        chk("R2 addr crit1", 64'(addr_out), 64'h2000_0008);
        for (int n = 0; n < 4; n++) begin
            tick(); bus_grant = 1'b0; beat_valid = 1'b1; beat_data = dw(8'h22, n); #1;
            chk("R7 writes continue", 64'(lb_we), 1);
        end
        tick(); beat_valid = 1'b0; #1;
        chk("R7 held valid", 64'(q_valid), 1);
        chk("R7 held pair", {q_insn1, q_insn0}, dw(8'h22, 0));
        tick(); q_ready = 1'b1;
        for (int n = 0; n < 4; n++) tick();
        #1;
        chk("R7 stall released", 64'(fetch_stall), 0);
        chk("R7 pair count", 64'(qn), 4);
        for (int n = 0; n < 4; n++) begin
            chk("R7 order", (n < qn) ? qlog[n] : 64'hX, dw(8'h22, n));
            chk("R4 wrapped slots", (n < lbn) ? 64'(lblog[n]) : 64'hX, 64'((n + 1) % 4));
        end
    endtask

    // R8: flush while still arbitrating
    task automatic t_flush_arb();
        miss_valid = 1'b1; miss_addr = 32'h4000_0000;
        tick(); miss_valid = 1'b0; #1;
        chk("R8 req raised", 64'(bus_req), 1);
        tick(); flush = 1'b1; bus_grant = 1'b1; #1;
        chk("R8 address suppressed", 64'(addr_valid), 0);
        tick(); flush = 1'b0; bus_grant = 1'b0; #1;
        chk("R8 req dropped", 64'(bus_req), 0);
        chk("R8 stall dropped", 64'(fetch_stall), 0);
    endtask

    // R9: flush in the middle of the burst
    task automatic t_flush_data();
        clear_logs();
        miss_valid = 1'b1; miss_addr = 32'h3000_0018;
        tick(); miss_valid = 1'b0; bus_grant = 1'b1;
        tick(); bus_grant = 1'b0; beat_valid = 1'b1; beat_data = dw(8'h33, 0); #1;
        chk("R4 crit3 slot", 64'(lb_idx), 3);
        tick(); beat_data = dw(8'h33, 1); flush = 1'b1; #1;
        chk("R9 write dropped on flush", 64'(lb_we), 0);
        tick(); flush = 1'b0; beat_data = dw(8'h33, 2); #1;
        chk("R9 later beat dropped", 64'(lb_we), 0);
        chk("R9 queue emptied", 64'(q_valid), 0);
        chk("R9 stall during drain", 64'(fetch_stall), 1);
        tick(); beat_data = dw(8'h33, 3); #1;
        chk("R9 last beat dropped", 64'(lb_we), 0);
        chk("R9 stall to end of burst", 64'(fetch_stall), 1);
        tick(); beat_valid = 1'b0; #1;
        chk("R9 stall released", 64'(fetch_stall), 0);
        tick(); tick(); #1;
        chk("R9 one write only", 64'(lbn), 1);
        chk("R9 no pair forwarded", 64'(qn), 0);
    endtask

    // R3 R10: stray beats and a flush while idle
    task automatic t_idle();
        clear_logs();
        flush = 1'b1; miss_valid = 1'b1; miss_addr = 32'h5000_0000;
        beat_valid = 1'b1; beat_data = dw(8'h44, 0); #1;
        chk("R3 idle beat ignored", 64'(lb_we), 0);
        tick(); flush = 1'b0; miss_valid = 1'b0; beat_valid = 1'b0; #1;
        chk("R10 flushed miss ignored", 64'(bus_req), 0);
        chk("R10 no stall", 64'(fetch_stall), 0);
        chk("R3 no queue entry", 64'(q_valid), 0);
    endtask

    initial begin
        #1_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #12;
        t_reset();
        rst_n = 1'b1;
        tick();
        t_basic();
        tick(); tick();
        t_stall();
        tick(); tick();
        t_flush_arb();
        tick();
        t_flush_data();
        tick();
        t_idle();
        tick(); tick();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule